// File: doc/BRIEF.md
# I2C Slave Address Matcher and Status Engine

This block is the slave half of a byte-oriented I2C controller. It watches SCL and SDA for START and STOP and shifts in the address byte after each START. It compares that byte with a set of programmable own addresses, each with its own don't-care mask, and it also accepts the general call. Once selected, it steps through the slave receive or slave transmit sequence. At each step it posts an 8-bit status code and raises an event flag. The flag holds SCL low until software has reacted and cleared it.

Software sets an acknowledge-enable level before each byte. It supplies the byte to transmit when the block is addressed for read, and it reads the received byte and the index of the matching address slot. An input from the master side marks that the master lost arbitration during the current address byte. The block then reports the variant status codes for that case. Bus pins arrive raw and are synchronised inside the block. SDA is driven only as an open-drain pull-down enable.

Top module: `i2cs_slave_engine`

## Requirements
- R1: After reset, si_o, sda_oe_o and scl_hold_o are 0, status_o is 0xF8 and rx_data_o is 0x00.
- R2: The address byte is bits 7:1 of the received byte, and bit 0 is the direction (1 = read). Slot n matches when own_addr_i[8n+7:8n+1] equals the received address in every bit whose addr_mask_i[8n+7:8n+1] bit is 0; a set mask bit is a don't-care. When several slots match, the lowest index wins and goes to match_idx_o. A matching write address with aa_i=1 is acknowledged and gives status 0x60.
- R3: An address that matches no slot, or any address received while aa_i=0, is not acknowledged, sets no flag and changes no status. The bytes that follow, up to the next START, are ignored.
- R4: The received byte 0x00 is the general call. It is acknowledged with status 0x70 when bit 0 of any slot's own address is 1, and match_idx_o then gives the lowest such slot. With no slot enabled, it is ignored as in R3.
- R5: In receive mode each data byte appears on rx_data_o. With aa_i=1 it is acknowledged, with status 0x80 (own address) or 0x90 (general call). With aa_i=0 it is not acknowledged, with status 0x88 or 0x98, and the block leaves the addressed state, so a following STOP reports nothing.
- R6: A matching read address with aa_i=1 gives status 0xA8. On clearing the flag, tx_data_i is loaded and sent MSB first. A master ACK gives 0xB8, or 0xC8 if aa_i was 0 when the byte was loaded. A master NACK gives 0xC0. After 0xC0 or 0xC8 the block is no longer addressed.
- R7: A STOP or repeated START seen while addressed (receive or transmit) gives status 0xA0. After a repeated START the next address byte is matched again.
- R8: si_o rises in the cycle status_o takes a new value, status_o changes only together with that, and si_o stays 1 until si_clr_i is pulsed.
- R9: scl_hold_o is 1 while si_o is 1 and 0 otherwise.
- R10: sda_oe_o changes only while SCL is low, so every bit sent holds steady across the SCL high time.
- R11: With arb_lost_i=1 during address acceptance, an own write address gives 0x68, the general call gives 0x78 and an own read address gives 0xB0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| own_addr_i | input | NUM_ADDR*8 | Per slot: address in bits 7:1, general call enable in bit 0 |
| addr_mask_i | input | NUM_ADDR*8 | Per slot: don't-care mask in bits 7:1 |
| aa_i | input | 1 | Acknowledge enable |
| arb_lost_i | input | 1 | Master lost arbitration in this address byte |
| si_clr_i | input | 1 | Pulse to clear the event flag |
| tx_data_i | input | 8 | Byte to transmit in read mode |
| sda_oe_o | output | 1 | Pull SDA low |
| scl_hold_o | output | 1 | Hold SCL low (clock stretch) |
| si_o | output | 1 | Event flag |
| status_o | output | 8 | Status code |
| rx_data_o | output | 8 | Last received data byte |
| match_idx_o | output | IDX_W | Slot that selected the block |

## Verification
Address bytes are run from a table against four slots. The slots are set up so that an exact match, a masked match in low bits, a masked match in the top bit, an overlap of two slots, the general call, and near misses in both a masked and an unmasked bit each give a different acknowledge, status and index. Directed sequences then cover receive with and without acknowledge under both selection kinds. They also cover read with master ACK, master NACK and last-byte ACK, repeated START between transfers, and the arbitration-lost variants. Each ends with a STOP whose status report, or absence of one, shows whether the block was still addressed.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_RX, ST_TX} i2cs_state_e;

  localparam logic [7:0] STAT_NONE      = 8'hF8;
  localparam logic [7:0] STAT_SLAW      = 8'h60;
  localparam logic [7:0] STAT_AL_SLAW   = 8'h68;
  localparam logic [7:0] STAT_GC        = 8'h70;
  localparam logic [7:0] STAT_AL_GC     = 8'h78;
  localparam logic [7:0] STAT_RX_ACK    = 8'h80;
  localparam logic [7:0] STAT_RX_NACK   = 8'h88;
  localparam logic [7:0] STAT_GRX_ACK   = 8'h90;
  localparam logic [7:0] STAT_GRX_NACK  = 8'h98;
  localparam logic [7:0] STAT_STOP      = 8'hA0;
  localparam logic [7:0] STAT_SLAR      = 8'hA8;
  localparam logic [7:0] STAT_AL_SLAR   = 8'hB0;
  localparam logic [7:0] STAT_TX_ACK    = 8'hB8;
  localparam logic [7:0] STAT_TX_NACK   = 8'hC0;
  localparam logic [7:0] STAT_TX_LAST   = 8'hC8;

  localparam logic [3:0] BITS_PER_BYTE = 4'd8;
  localparam logic [3:0] ACK_SLOT      = 4'd9;
endpackage

// File: rtl/i2cs_bus_cond.sv
module i2cs_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] scl_sync, sda_sync;
  logic       scl_prev, sda_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_prev <= scl_sync[1];
      sda_prev <= sda_sync[1];
    end
  end

  assign sda_o      = sda_sync[1];
  assign scl_rise_o = scl_sync[1] & ~scl_prev;
  assign scl_fall_o = ~scl_sync[1] & scl_prev;
  // SDA moving while SCL stays high
  assign start_o    = scl_sync[1] & scl_prev & sda_prev & ~sda_sync[1];
  assign stop_o     = scl_sync[1] & scl_prev & ~sda_prev & sda_sync[1];
endmodule

// File: rtl/i2cs_addr_match.sv
module i2cs_addr_match #(
  parameter int NUM_ADDR = 4,
  parameter int IDX_W    = 2
) (
  input  logic [7:0]            addr_byte_i,
  input  logic [NUM_ADDR*8-1:0] own_addr_i,
  input  logic [NUM_ADDR*8-1:0] addr_mask_i,
  output logic                  own_hit_o,
  output logic                  gc_hit_o,
  output logic [IDX_W-1:0]      idx_o
);
  localparam logic [7:0] CMP_BITS = 8'hFE;

  logic [NUM_ADDR-1:0] hit_vec, gc_vec, sel_vec;
  logic                is_gc;

  for (genvar g = 0; g < NUM_ADDR; g++) begin : g_slot
    logic [7:0] own, msk;
    assign own        = own_addr_i[g*8 +: 8];
    assign msk        = addr_mask_i[g*8 +: 8];
    assign hit_vec[g] = ((addr_byte_i ^ own) & ~msk & CMP_BITS) == 8'h00;
    assign gc_vec[g]  = own[0];
  end

  assign is_gc     = (addr_byte_i == 8'h00);
  assign own_hit_o = ~is_gc & (|hit_vec);
  assign gc_hit_o  = is_gc & (|gc_vec);
  assign sel_vec   = is_gc ? gc_vec : hit_vec;

  always_comb begin
    idx_o = '0;
    for (int i = NUM_ADDR - 1; i >= 0; i--) begin
      if (sel_vec[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/i2cs_seq.sv
module i2cs_seq
  import i2cs_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             sda_i,
  input  logic             aa_i,
  input  logic             arb_lost_i,
  input  logic             si_clr_i,
  input  logic [7:0]       tx_data_i,
  input  logic             own_hit_i,
  input  logic             gc_hit_i,
  input  logic [IDX_W-1:0] hit_idx_i,
  output logic [7:0]       addr_byte_o,
  output logic             sda_oe_o,
  output logic             si_o,
  output logic [7:0]       status_o,
  output logic [7:0]       rx_data_o,
  output logic [IDX_W-1:0] match_idx_o
);
  i2cs_state_e      state_q;
  logic [3:0]       cnt_q;
  logic [7:0]       sh_q, stat_q, rx_q;
  logic             gc_sel_q, ack_q, last_q, sda_oe_q, si_q;
  logic [IDX_W-1:0] idx_q;
  logic             addressed;

  assign addressed = (state_q == ST_RX) || (state_q == ST_TX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      stat_q   <= STAT_NONE;
      rx_q     <= '0;
      gc_sel_q <= 1'b0;
      ack_q    <= 1'b0;
      last_q   <= 1'b0;
      sda_oe_q <= 1'b0;
      si_q     <= 1'b0;
      idx_q    <= '0;
    end else begin
      if (si_clr_i) si_q <= 1'b0;
      if (start_i || stop_i) begin
        if (addressed) begin
          stat_q <= STAT_STOP;
          si_q   <= 1'b1;
        end
        state_q  <= start_i ? ST_ADDR : ST_IDLE;
        cnt_q    <= '0;
        sda_oe_q <= 1'b0;
      end else begin
        case (state_q)
          ST_ADDR, ST_RX: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 4'd1;
              if (cnt_q < BITS_PER_BYTE) sh_q <= {sh_q[6:0], sda_i};
            end
            if (scl_fall_i) begin
              if (cnt_q == BITS_PER_BYTE) begin
                if (state_q == ST_ADDR) begin
                  if ((own_hit_i || gc_hit_i) && aa_i) begin
                    sda_oe_q <= 1'b1;
                    gc_sel_q <= gc_hit_i;
                    idx_q    <= hit_idx_i;
                  end else begin
                    state_q <= ST_IDLE;
                  end
                end else begin
                  sda_oe_q <= aa_i;
                  ack_q    <= aa_i;
                end
              end else if (cnt_q == ACK_SLOT) begin
                sda_oe_q <= 1'b0;
                cnt_q    <= '0;
                si_q     <= 1'b1;
                if (state_q == ST_ADDR) begin
                  if (gc_sel_q) begin
                    stat_q  <= arb_lost_i ? STAT_AL_GC : STAT_GC;
                    state_q <= ST_RX;
                  end else if (sh_q[0]) begin
                    stat_q  <= arb_lost_i ? STAT_AL_SLAR : STAT_SLAR;
                    state_q <= ST_TX;
                  end else begin
                    stat_q  <= arb_lost_i ? STAT_AL_SLAW : STAT_SLAW;
                    state_q <= ST_RX;
                  end
                end else begin
                  rx_q <= sh_q;
                  if (gc_sel_q) stat_q <= ack_q ? STAT_GRX_ACK : STAT_GRX_NACK;
                  else          stat_q <= ack_q ? STAT_RX_ACK : STAT_RX_NACK;
                  if (!ack_q) state_q <= ST_IDLE;
                end
              end
            end
          end
          ST_TX: begin
            if (si_q && si_clr_i && cnt_q == 4'd0) begin
              sh_q     <= tx_data_i;
              last_q   <= ~aa_i;
              sda_oe_q <= ~tx_data_i[7];
            end
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 4'd1;
              if (cnt_q == BITS_PER_BYTE) ack_q <= ~sda_i;
            end
            if (scl_fall_i) begin
              if (cnt_q >= 4'd1 && cnt_q < BITS_PER_BYTE) begin
                sh_q     <= {sh_q[6:0], 1'b0};
                sda_oe_q <= ~sh_q[6];
              end else if (cnt_q == BITS_PER_BYTE) begin
                sda_oe_q <= 1'b0;
              end else if (cnt_q == ACK_SLOT) begin
                cnt_q <= '0;
                si_q  <= 1'b1;
                if (!ack_q) begin
                  stat_q  <= STAT_TX_NACK;
                  state_q <= ST_IDLE;
                end else if (last_q) begin
                  stat_q  <= STAT_TX_LAST;
                  state_q <= ST_IDLE;
                end else begin
                  stat_q <= STAT_TX_ACK;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign addr_byte_o = sh_q;
  assign sda_oe_o    = sda_oe_q;
  assign si_o        = si_q;
  assign status_o    = stat_q;
  assign rx_data_o   = rx_q;
  assign match_idx_o = idx_q;
endmodule

// File: rtl/i2cs_slave_engine.sv
module i2cs_slave_engine #(
  parameter int NUM_ADDR = 4,
  localparam int IDX_W   = (NUM_ADDR > 1) ? $clog2(NUM_ADDR) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [NUM_ADDR*8-1:0] own_addr_i,
  input  logic [NUM_ADDR*8-1:0] addr_mask_i,
  input  logic                  aa_i,
  input  logic                  arb_lost_i,
  input  logic                  si_clr_i,
  input  logic [7:0]            tx_data_i,
  output logic                  sda_oe_o,
  output logic                  scl_hold_o,
  output logic                  si_o,
  output logic [7:0]            status_o,
  output logic [7:0]            rx_data_o,
  output logic [IDX_W-1:0]      match_idx_o
);
  logic             sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [7:0]       addr_byte;
  logic             own_hit, gc_hit;
  logic [IDX_W-1:0] hit_idx;

  i2cs_bus_cond u_cond (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  i2cs_addr_match #(.NUM_ADDR(NUM_ADDR), .IDX_W(IDX_W)) u_match (
    .addr_byte_i (addr_byte),
    .own_addr_i  (own_addr_i),
    .addr_mask_i (addr_mask_i),
    .own_hit_o   (own_hit),
    .gc_hit_o    (gc_hit),
    .idx_o       (hit_idx)
  );

  i2cs_seq #(.IDX_W(IDX_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start_ev),
    .stop_i      (stop_ev),
    .sda_i       (sda_s),
    .aa_i        (aa_i),
    .arb_lost_i  (arb_lost_i),
    .si_clr_i    (si_clr_i),
    .tx_data_i   (tx_data_i),
    .own_hit_i   (own_hit),
    .gc_hit_i    (gc_hit),
    .hit_idx_i   (hit_idx),
    .addr_byte_o (addr_byte),
    .sda_oe_o    (sda_oe_o),
    .si_o        (si_o),
    .status_o    (status_o),
    .rx_data_o   (rx_data_o),
    .match_idx_o (match_idx_o)
  );

  assign scl_hold_o = si_o;
endmodule

// File: rtl/i2cs_slave_chk.sv
module i2cs_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_i,
  input logic       si_clr_i,
  input logic       sda_oe_o,
  input logic       si_o,
  input logic [7:0] status_o,
  input logic [7:0] rx_data_o
);
  AST_SDA_ONLY_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !scl_i); // R10

  AST_SI_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (si_o && !si_clr_i) |=> si_o); // R8

  AST_STATUS_WITH_SI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(status_o) |-> si_o); // R8

  AST_RX_DATA_WITH_RX_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rx_data_o) |-> (si_o && (status_o[7:4] == 4'h8 || status_o[7:4] == 4'h9))); // R5
endmodule

bind i2cs_slave_engine i2cs_slave_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .scl_i     (scl_i),
  .si_clr_i  (si_clr_i),
  .sda_oe_o  (sda_oe_o),
  .si_o      (si_o),
  .status_o  (status_o),
  .rx_data_o (rx_data_o)
);

// File: tb/i2cs_slave_engine_test.sv
module i2cs_slave_engine_test;
  localparam int P = 8;
  localparam int N = 9;
  // {address byte, expect ack, expect status, expect index}
  localparam logic [18:0] VEC [0:N-1] = '{
    {8'hA0, 1'b1, 8'h60, 2'd0},
    {8'h6A, 1'b1, 8'h60, 2'd1},
    {8'hE0, 1'b1, 8'h60, 2'd3},
    {8'h60, 1'b1, 8'h60, 2'd1},
    {8'h90, 1'b1, 8'h60, 2'd2},
    {8'h00, 1'b1, 8'h70, 2'd2},
    {8'hA2, 1'b0, 8'h00, 2'd0},
    {8'h70, 1'b0, 8'h00, 2'd0},
    {8'hC0, 1'b0, 8'h00, 2'd0}
  };

  logic        clk = 0, rst_ni = 0;
  logic        m_scl = 1, m_sda = 1;
  logic        aa = 1, arb = 0, si_clr = 0;
  logic [7:0]  tx = 0;
  logic [31:0] own  = {8'h60, 8'h91, 8'h62, 8'hA0};
  logic [31:0] mask = {8'h80, 8'h00, 8'h0E, 8'h00};
  logic        sda_oe, scl_hold, si;
  logic [7:0]  status, rx_data;
  logic [1:0]  midx;
  logic        sda_bus;
  int          n_chk = 0, n_err = 0;

  assign sda_bus = m_sda & ~sda_oe;
  always #4 clk = ~clk;

  i2cs_slave_engine uut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(m_scl), .sda_i(sda_bus),
    .own_addr_i(own), .addr_mask_i(mask), .aa_i(aa), .arb_lost_i(arb),
    .si_clr_i(si_clr), .tx_data_i(tx), .sda_oe_o(sda_oe),
    .scl_hold_o(scl_hold), .si_o(si), .status_o(status),
    .rx_data_o(rx_data), .match_idx_o(midx)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1; wt(P); m_scl = 1; wt(P); m_sda = 0; wt(P); m_scl = 0; wt(P);
  endtask

  task automatic bus_stop();
    m_sda = 0; wt(P); m_scl = 1; wt(P); m_sda = 1; wt(P);
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wt(P); m_scl = 1; wt(P); m_scl = 0;
    end
    m_sda = 1; wt(P); m_scl = 1; wt(P/2); ack = ~sda_bus; wt(P/2); m_scl = 0; wt(P);
  endtask

  task automatic rd_byte(input logic mack, output logic [7:0] b);
    logic early;
    for (int i = 7; i >= 0; i--) begin
      m_sda = 1; wt(P); m_scl = 1; wt(1); early = sda_bus; wt(P/2);
      b[i] = sda_bus;
      chk(early == sda_bus, "R10", early, sda_bus);
      wt(P/2 - 1); m_scl = 0;
    end
    m_sda = ~mack; wt(P); m_scl = 1; wt(P); m_scl = 0; wt(P);
  endtask

  task automatic clr_si();
    @(negedge clk) si_clr = 1;
    @(negedge clk) si_clr = 0;
    wt(2);
  endtask

  task automatic expect_ev(input logic [7:0] st, input string req);
    chk(si == 1'b1, req, si, 1);
    chk(status == st, req, status, st);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    wt(5);
    chk(si == 0 && sda_oe == 0 && scl_hold == 0, "R1", {si, sda_oe, scl_hold}, 0);
    chk(status == 8'hF8, "R1", status, 8'hF8);
    chk(rx_data == 8'h00, "R1", rx_data, 0);
    rst_ni = 1; wt(5);

    // address table: R2 own match, R4 general call, R3 miss
    for (int k = 0; k < N; k++) begin
      logic [7:0] ab;
      logic ea;
      string rq;
      ab = VEC[k][18:11]; ea = VEC[k][10];
      rq = ea ? ((ab == 8'h00) ? "R4" : "R2") : "R3";
      bus_start();
      wr_byte(ab, ack);
      chk(ack == ea, rq, ack, ea);
      if (ea) begin
        expect_ev(VEC[k][9:2], rq);
        chk(midx == VEC[k][1:0], rq, midx, VEC[k][1:0]);
        wt(20);
        chk(si == 1 && scl_hold == 1, "R9", {si, scl_hold}, 2'b11);
        clr_si();
        chk(si == 0 && scl_hold == 0, "R8", {si, scl_hold}, 0);
        bus_stop();
        expect_ev(8'hA0, "R7");
        clr_si();
      end else begin
        chk(si == 0, rq, si, 0);
        wr_byte(8'h55, ack);
        chk(ack == 0 && si == 0, "R3", {ack, si}, 0);
        bus_stop();
        chk(si == 0, "R3", si, 0);
      end
    end

    // aa=0 on a matching address is ignored (R3)
    aa = 0; bus_start(); wr_byte(8'hA0, ack);
    chk(ack == 0 && si == 0, "R3", {ack, si}, 0);
    bus_stop(); aa = 1;

    // own-address receive: ACK then NACK (R5)
    bus_start(); wr_byte(8'hA0, ack); clr_si();
    wr_byte(8'h3C, ack);
    chk(ack == 1, "R5", ack, 1); expect_ev(8'h80, "R5");
    chk(rx_data == 8'h3C, "R5", rx_data, 8'h3C); clr_si();
    aa = 0; wr_byte(8'hC5, ack);
    chk(ack == 0, "R5", ack, 0); expect_ev(8'h88, "R5");
    chk(rx_data == 8'hC5, "R5", rx_data, 8'hC5); clr_si();
    aa = 1; bus_stop();
    chk(si == 0, "R5", si, 0);

    // general-call receive (R4, R5)
    bus_start(); wr_byte(8'h00, ack); expect_ev(8'h70, "R4"); clr_si();
    wr_byte(8'h5A, ack); expect_ev(8'h90, "R5");
    chk(rx_data == 8'h5A, "R5", rx_data, 8'h5A); clr_si();
    aa = 0; wr_byte(8'h11, ack); expect_ev(8'h98, "R5"); clr_si();
    aa = 1; bus_stop();
    chk(si == 0, "R5", si, 0);

    // receive, repeated START, then read with ACK and last byte (R7, R6)
    bus_start(); wr_byte(8'h6A, ack); clr_si();
    wr_byte(8'h01, ack); expect_ev(8'h80, "R5"); clr_si();
    bus_start(); expect_ev(8'hA0, "R7"); clr_si();
    wr_byte(8'hA1, ack);
    chk(ack == 1, "R7", ack, 1); expect_ev(8'hA8, "R6");
    chk(midx == 2'd0, "R6", midx, 0);
    tx = 8'h96; clr_si();
    rd_byte(1'b1, rb);
    chk(rb == 8'h96, "R6", rb, 8'h96); expect_ev(8'hB8, "R6");
    tx = 8'h3B; aa = 0; clr_si(); aa = 1;
    rd_byte(1'b1, rb);
    chk(rb == 8'h3B, "R6", rb, 8'h3B); expect_ev(8'hC8, "R6"); clr_si();
    bus_stop();
    chk(si == 0, "R6", si, 0);

    // read ending in master NACK (R6)
    bus_start(); wr_byte(8'hE1, ack); expect_ev(8'hA8, "R6");
    chk(midx == 2'd3, "R6", midx, 3);
    tx = 8'hF0; clr_si();
    rd_byte(1'b0, rb);
    chk(rb == 8'hF0, "R6", rb, 8'hF0); expect_ev(8'hC0, "R6"); clr_si();
    bus_stop();
    chk(si == 0, "R6", si, 0);

    // arbitration-lost variants (R11)
    arb = 1;
    bus_start(); wr_byte(8'hA0, ack); expect_ev(8'h68, "R11"); clr_si();
    bus_stop(); expect_ev(8'hA0, "R7"); clr_si();
    bus_start(); wr_byte(8'h00, ack); expect_ev(8'h78, "R11"); clr_si();
    bus_stop(); clr_si();
    bus_start(); wr_byte(8'h91, ack); expect_ev(8'hB0, "R11");
    tx = 8'hFF; clr_si();
    bus_stop(); expect_ev(8'hA0, "R7"); clr_si();
    arb = 0;

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule